// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a memory-mapped watchdog with two stages of expiry. An interval counter of N bits runs only while two enable bits, kept in two separate registers, are both set. When the counter wraps for the first time, the block sets a state flag and raises an interrupt. If software has not cleared that flag by the time the counter wraps again, the block emits a one-cycle reset pulse and latches a reset-status flag. Software services the watchdog by writing a one to the state bit. That write clears the flag and also restarts the interval from zero.

Three 32-bit word registers sit behind a simple single-cycle bus. A free-running timebase counter can be read so that software can see the clock running. Read data is registered: it appears one clock after the address is presented. The interrupt and reset outputs are registered levels. The bus fabric, the interrupt routing and the system reset sequencing all sit outside the block.

Top module: `twostage_wdog`

## Requirements
- R1: After a synchronous reset, both control words read zero and `wdog_irq` and `wdog_rst` are low.
- R2: The word registers sit at byte offsets 0x0 (control word A), 0x4 (control word B) and 0x8 (timebase). Control word A reads back as bit 3 = reset-status flag, bit 2 = state flag, bit 1 = enable one and bit 0 = enable two. Control word B reads back enable two at bit 0. A write to word A sets enable one from bit 1 and never changes enable two.
- R3: The interval advances only while both enables are set. While either enable is clear, the interval is held at zero, and no interrupt or reset can come from it.
- R4: With both enables set, the first wrap of the interval sets the state flag. The wrap happens 2^N clocks after the edge that armed the block. `wdog_irq` goes high one clock later.
- R5: `wdog_irq` equals the state flag ANDed with both enables, delayed by one register stage. Clearing an enable drops `wdog_irq` but leaves the state flag set.
- R6: A wrap that occurs while the state flag is set drives `wdog_rst` high for exactly one clock and sets the reset-status flag in the same edge.
- R7: Writing word A with bit 2 = 1 clears the state flag and restarts the interval from zero. The next wrap therefore comes a full 2^N clocks later and only raises the interrupt.
- R8: Writing word A with bit 3 = 1 clears the reset-status flag. Writing zeros to bits 3 and 2 leaves both flags unchanged.
- R9: The timebase increments every clock. Two reads issued g idle clocks apart differ by g+1. Writes to offset 0x8 are ignored.
- R10: Offsets other than the three mapped ones read zero. `bus_rdata` changes only on the clock edge that follows an address change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the word register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| wdog_irq | output | 1 | First-stage expiry interrupt level |
| wdog_rst | output | 1 | Second-stage expiry reset pulse |

## Verification
The expiry path is driven in four ways:
- With only one enable set at a time, which isolates the AND of the two enables.
- With a full unserviced run, which separates the first wrap (interrupt only) from the second (reset pulse) at their exact edges.
- With service writes at random points inside the interval, which shows that each service restarts the count rather than merely clearing the flag.
- With writes that carry zeros in the clear bits, which shows that clearing is write-one only.

Timebase reads at random gaps, some with writes to the timebase offset in between, separate a true per-clock counter from a stalled or writable one.

// File: rtl/twdog_pkg.sv
package twdog_pkg;
  typedef enum logic [1:0] {SEL_CSR_A, SEL_CSR_B, SEL_TBASE, SEL_NONE} reg_sel_e;

  localparam int unsigned WORD_CSR_A = 0;
  localparam int unsigned WORD_CSR_B = 1;
  localparam int unsigned WORD_TBASE = 2;

  localparam int unsigned BIT_EN_TWO = 0;
  localparam int unsigned BIT_EN_ONE = 1;
  localparam int unsigned BIT_STATE  = 2;
  localparam int unsigned BIT_RSTAT  = 3;

  function automatic reg_sel_e word_to_sel(input logic [29:0] word);
    case (word)
      30'(WORD_CSR_A): return SEL_CSR_A;
      30'(WORD_CSR_B): return SEL_CSR_B;
      30'(WORD_TBASE): return SEL_TBASE;
      default:         return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/twdog_timebase.sv
module twdog_timebase #(
  parameter int TB_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TB_W-1:0] tbase
);
  always_ff @(posedge clk) begin
    if (rst) tbase <= '0;
    else     tbase <= tbase + 1'b1;
  end
endmodule

// File: rtl/twdog_interval.sv
module twdog_interval #(
  parameter int INTERVAL_LOG2 = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic restart,
  output logic ovf
);
  logic [INTERVAL_LOG2-1:0] cnt;

  // a restart and a wrap in the same cycle: restart wins
  assign ovf = armed && !restart && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst || !armed || restart) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/twdog_expiry.sv
module twdog_expiry (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic ovf,
  input  logic kick,
  input  logic clr_rst_flag,
  output logic state_flag,
  output logic rst_flag,
  output logic irq,
  output logic rst_pulse
);
  logic second_ovf;
  assign second_ovf = ovf && state_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_flag <= 1'b0;
      rst_flag   <= 1'b0;
      irq        <= 1'b0;
      rst_pulse  <= 1'b0;
    end else begin
      rst_pulse <= second_ovf;
      irq       <= state_flag && armed;
      if (kick)     state_flag <= 1'b0;
      else if (ovf) state_flag <= 1'b1;
      if (second_ovf)        rst_flag <= 1'b1;
      else if (clr_rst_flag) rst_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/twdog_regs.sv
module twdog_regs
  import twdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TB_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              state_flag,
  input  logic              rst_flag,
  input  logic [TB_W-1:0]   tbase,
  output logic              en_one,
  output logic              en_two,
  output logic              kick,
  output logic              clr_rst_flag,
  output logic [31:0]       bus_rdata
);
  logic [29:0] word_idx;
  reg_sel_e    sel;
  logic        wr_a, wr_b;
  logic [31:0] rd_next;
  logic        unused_bits;

  assign word_idx    = 30'(bus_addr[ADDR_W-1:2]);
  assign sel         = word_to_sel(word_idx);
  assign wr_a        = bus_wr && (sel == SEL_CSR_A);
  assign wr_b        = bus_wr && (sel == SEL_CSR_B);
  assign kick        = wr_a && bus_wdata[BIT_STATE];
  assign clr_rst_flag = wr_a && bus_wdata[BIT_RSTAT];
  assign unused_bits = ^{bus_wdata[31:4], bus_addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_one <= 1'b0;
      en_two <= 1'b0;
    end else begin
      if (wr_a) en_one <= bus_wdata[BIT_EN_ONE];
      if (wr_b) en_two <= bus_wdata[BIT_EN_TWO];
    end
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_CSR_A: begin
        rd_next[BIT_RSTAT]  = rst_flag;
        rd_next[BIT_STATE]  = state_flag;
        rd_next[BIT_EN_ONE] = en_one;
        rd_next[BIT_EN_TWO] = en_two;
      end
      SEL_CSR_B: rd_next[BIT_EN_TWO] = en_two;
      SEL_TBASE: rd_next = 32'(tbase);
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog #(
  parameter int ADDR_W        = 4,
  parameter int TB_W          = 32,
  parameter int INTERVAL_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdog_irq,
  output logic              wdog_rst
);
  logic [TB_W-1:0] tbase;
  logic en_one, en_two, armed, kick, clr_rst_flag, ovf;
  logic state_flag, rst_flag;

  assign armed = en_one && en_two;

  twdog_timebase #(.TB_W(TB_W)) u_tbase (
    .clk(clk), .rst(rst), .tbase(tbase)
  );

  twdog_regs #(.ADDR_W(ADDR_W), .TB_W(TB_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .state_flag(state_flag), .rst_flag(rst_flag),
    .tbase(tbase), .en_one(en_one), .en_two(en_two), .kick(kick),
    .clr_rst_flag(clr_rst_flag), .bus_rdata(bus_rdata)
  );

  twdog_interval #(.INTERVAL_LOG2(INTERVAL_LOG2)) u_ivl (
    .clk(clk), .rst(rst), .armed(armed), .restart(kick), .ovf(ovf)
  );

  twdog_expiry u_exp (
    .clk(clk), .rst(rst), .armed(armed), .ovf(ovf), .kick(kick),
    .clr_rst_flag(clr_rst_flag), .state_flag(state_flag),
    .rst_flag(rst_flag), .irq(wdog_irq), .rst_pulse(wdog_rst)
  );
endmodule

// File: rtl/twdog_checker.sv
module twdog_checker #(
  parameter int ADDR_W = 4,
  parameter int TB_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              kick_bit,
  input logic              wdog_irq,
  input logic              wdog_rst,
  input logic [TB_W-1:0]   tbase,
  input logic              state_flag,
  input logic              rst_flag,
  input logic              en_one,
  input logic              en_two
);
  logic kick_wr;
  assign kick_wr = bus_wr && (bus_addr[ADDR_W-1:2] == '0) && kick_bit;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |=> !wdog_rst); // R6
  AST_RST_AFTER_IRQ: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |-> $past(wdog_irq)); // R6
  AST_RSTAT_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_flag) |-> wdog_rst); // R6
  AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    wdog_irq |-> $past(en_one && en_two)); // R5
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(en_one && en_two) |=> !wdog_rst); // R3
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    kick_wr |=> !state_flag); // R7
  AST_TB_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tbase == TB_W'($past(tbase) + 1'b1)); // R9
endmodule

bind twostage_wdog twdog_checker #(.ADDR_W(ADDR_W), .TB_W(TB_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .kick_bit(bus_wdata[2]), .wdog_irq(wdog_irq), .wdog_rst(wdog_rst),
  .tbase(tbase), .state_flag(state_flag), .rst_flag(rst_flag),
  .en_one(en_one), .en_two(en_two)
);

// File: tb/test_twostage_wdog.sv
module test_twostage_wdog;
  localparam int N   = 5;
  localparam int IVL = 1 << N;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdog_irq, wdog_rst;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  twostage_wdog #(.ADDR_W(4), .TB_W(32), .INTERVAL_LOG2(N)) i_twostage_wdog (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdog_irq(wdog_irq), .wdog_rst(wdog_rst)
  );

  function automatic logic [31:0] exp_csr_a(bit rs, bit st, bit e1, bit e2);
    return {28'd0, rs, st, e1, e2};
  endfunction

  function automatic logic [31:0] exp_tb_delta(int unsigned gap);
    return 32'(gap + 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic watch(int n, output int irqs, output int rsts);
    irqs = 0; rsts = 0;
    repeat (n) begin
      @(posedge clk); @(negedge clk);
      if (wdog_irq) irqs++;
      if (wdog_rst) rsts++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b;
    int irqs, rsts;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 irq", 32'(wdog_irq), 0);
    check("R1 rst", 32'(wdog_rst), 0);
    rd(4'h0, v); check("R1 word A", v, 0);
    rd(4'h4, v); check("R1 word B", v, 0);

    // R2 enable two is not writable through word A
    wr(4'h0, 32'h1);
    rd(4'h0, v); check("R2 word A bit0 ignored", v, 0);
    rd(4'h4, v); check("R2 word B", v, 0);
    wr(4'h4, 32'h1);
    rd(4'h0, v); check("R2 word A mirrors en two", v, exp_csr_a(0, 0, 0, 1));
    rd(4'h4, v); check("R2 word B en two", v, 1);

    // R3 only one enable set at a time
    watch(3 * IVL, irqs, rsts);
    check("R3 en two only irq", 32'(irqs), 0);
    check("R3 en two only rst", 32'(rsts), 0);
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h2);
    watch(3 * IVL, irqs, rsts);
    check("R3 en one only irq", 32'(irqs), 0);
    check("R3 en one only rst", 32'(rsts), 0);
    rd(4'h0, v); check("R3 word A", v, exp_csr_a(0, 0, 1, 0));

    // R4 arming edge is this write; first wrap after IVL edges
    wr(4'h4, 32'h1);
    step(IVL);
    check("R4 irq before first wrap", 32'(wdog_irq), 0);
    step(1);
    check("R4 irq after first wrap", 32'(wdog_irq), 1);
    rd(4'h0, v); check("R4 state flag", v, exp_csr_a(0, 1, 1, 1));

    // R6 second wrap at 2*IVL edges after arming
    step(IVL - 3);
    check("R6 rst before second wrap", 32'(wdog_rst), 0);
    step(1);
    check("R6 rst pulse", 32'(wdog_rst), 1);
    step(1);
    check("R6 rst one cycle", 32'(wdog_rst), 0);
    rd(4'h0, v); check("R6 reset status", v, exp_csr_a(1, 1, 1, 1));

    // R8 zeros leave flags; one clears reset status
    wr(4'h0, 32'h2);
    rd(4'h0, v); check("R8 zero write keeps flags", v, exp_csr_a(1, 1, 1, 1));
    wr(4'h0, 32'hA);
    rd(4'h0, v); check("R8 clear reset status", v, exp_csr_a(0, 1, 1, 1));

    // R5 disarm gates irq but keeps the flag
    wr(4'h0, 32'h0);
    step(1);
    check("R5 irq gated", 32'(wdog_irq), 0);
    rd(4'h0, v); check("R5 flag kept", v, exp_csr_a(0, 1, 0, 1));

    // R7 service restarts the full interval
    wr(4'h0, 32'h6);
    step(IVL);
    check("R7 irq before wrap", 32'(wdog_irq), 0);
    step(1);
    check("R7 irq after wrap", 32'(wdog_irq), 1);
    wr(4'h0, 32'h6);
    step(1);
    check("R7 irq cleared", 32'(wdog_irq), 0);
    watch(IVL - 1, irqs, rsts);
    check("R7 no irq in restarted interval", 32'(irqs), 0);
    check("R7 no rst in restarted interval", 32'(rsts), 0);
    step(1);
    check("R7 next wrap only interrupts", 32'(wdog_irq), 1);
    check("R7 next wrap no reset", 32'(wdog_rst), 0);

    // R7 random service points
    for (int i = 0; i < 12; i++) begin
      int d;
      wr(4'h0, 32'h0); wr(4'h4, 32'h0);
      wr(4'h4, 32'h1); wr(4'h0, 32'hE);
      for (int k = 0; k < 3; k++) begin
        d = 1 + int'($urandom % (IVL - 1));
        watch(d, irqs, rsts);
        check("R7 random service irq", 32'(irqs), 0);
        check("R7 random service rst", 32'(rsts), 0);
        wr(4'h0, 32'h6);
      end
    end

    // R9 timebase gaps, writes ignored
    for (int i = 0; i < 8; i++) begin
      int unsigned g;
      g = $urandom % 20;
      rd(4'h8, a); step(int'(g)); rd(4'h8, b);
      check("R9 timebase delta", b - a, exp_tb_delta(g));
    end
    rd(4'h8, a); wr(4'h8, 32'h0); rd(4'h8, b);
    check("R9 write to timebase ignored", b - a, exp_tb_delta(1));

    // R10 unmapped read and registered latency
    rd(4'h8, a);
    bus_addr = 4'hC;
    #1;
    check("R10 rdata holds until edge", bus_rdata, a);
    @(posedge clk); @(negedge clk);
    check("R10 unmapped reads zero", bus_rdata, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule